// File: doc/BRIEF.md
# Dual-Level Timer Compare Unit

This block watches a free-running 63-bit tick count. It holds two 64-bit compare words, one for the supervisor level and one for the hypervisor level. In each word, the top bit is an interrupt-off flag and the lower 63 bits are the compare value. When the count moves onto an enabled compare value, the block raises a one-cycle pulse.

The supervisor pulse is a set request for the system-tick bit (bit 16) of the soft interrupt register, which lives outside this block. The hypervisor pulse sets a one-bit pending flag. That flag drives the hypervisor interrupt request as a level. Software can also write the flag directly.

A small register port writes and reads both compare words and the pending flag. Writing a compare word rearms it. The tick counter itself and trap handling sit elsewhere.

Top module: `tcmp_top`

## Requirements
- R1: After reset, both compare words read as 0x8000_0000_0000_0000 (disabled, value zero). The pending flag reads 0, and `soft_tick_set`, `hyp_match` and `hyp_irq` are low.
- R2: Only compare bits 62:0 take part in matching, and all 63 of them must equal `tick_count`. A match registers one cycle later: the pulse is high in the cycle after the one in which the count equalled the compare value.
- R3: While bit 63 of a compare word is 1, that channel produces no pulse. Bit 63 is stored and read back as written.
- R4: A supervisor match produces a one-cycle high on `soft_tick_set`, which is the set request for soft interrupt bit 16.
- R5: A hypervisor match produces a one-cycle `hyp_match` pulse and sets the pending flag to 1 in the same edge. `hyp_irq` follows the pending flag.
- R6: Hypervisor matches are dropped while `strand_halted` is 1. Supervisor matches are not affected by `strand_halted`.
- R7: A write to the pending flag stores 1 if the written word is nonzero and 0 if it is zero. A hypervisor match in the same cycle wins and leaves the flag at 1.
- R8: Writing a compare word rearms it. A value equal to the current count does not fire until the count leaves it and returns. A value behind the count fires when the count reaches it.
- R9: A pulse fires only when the count becomes equal to the compare value. Holding the count at the compare value gives one pulse, not a train.
- R10: Read select 0 returns the supervisor compare word, 1 the hypervisor compare word, 2 the pending flag in bit 0 with zeros above, and 3 returns zero. Write select uses the same codes, and a write with select 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_count | input | 63 | Free-running tick count |
| strand_halted | input | 1 | Strand halted; mutes hypervisor matches |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target (0 sup compare, 1 hyp compare, 2 pending) |
| wr_data | input | 64 | Write data |
| rd_sel | input | 2 | Read source, same codes as `wr_sel` |
| rd_data | output | 64 | Read data (combinational) |
| soft_tick_set | output | 1 | One-cycle set request for soft interrupt bit 16 |
| hyp_match | output | 1 | One-cycle hypervisor match pulse |
| hyp_irq | output | 1 | Hypervisor interrupt request (pending flag level) |

## Verification
The embedded properties check these points on every cycle:
- A disabled channel stays silent.
- No pulse is ever two cycles long.
- Every pulse follows a cycle in which the low 63 compare bits equalled the count.
- Halting mutes the hypervisor channel.
- The pending flag obeys both its set path and its write path.

Only the bench scenarios can show the rest:
- Rearming after writes, including values at or behind the count.
- That all 63 bits take part in the compare.
- The read port encoding.
- That the supervisor channel ignores the halt input.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;
  localparam int TICK_W_DEF = 63;

  typedef enum logic [1:0] {
    SEL_SUP  = 2'd0,
    SEL_HYP  = 2'd1,
    SEL_PEND = 2'd2,
    SEL_NONE = 2'd3
  } tcmp_sel_e;

  // a compare word resets disabled: top bit set, value zero
  function automatic logic [TICK_W_DEF:0] reset_word();
    return {1'b1, {TICK_W_DEF{1'b0}}};
  endfunction
endpackage

// File: rtl/tcmp_channel.sv
module tcmp_channel #(
  parameter int TICK_W = 63,
  parameter bit GATE_ON_HALT = 1'b0,
  localparam int CMP_W = TICK_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TICK_W-1:0] tick,
  input  logic              halted,
  input  logic              wr_en,
  input  logic [CMP_W-1:0]  wr_data,
  output logic [CMP_W-1:0]  cmp_q,
  output logic              fire,
  output logic              match_q
);
  function automatic logic low_hit(logic [CMP_W-1:0] c, logic [TICK_W-1:0] t);
    return c[TICK_W-1:0] == t;
  endfunction

  logic eq_now;
  logic prev_eq;
  logic muted;

  assign eq_now = low_hit(cmp_q, tick);
  assign muted  = GATE_ON_HALT ? halted : 1'b0;
  assign fire   = eq_now & ~prev_eq & ~cmp_q[TICK_W] & ~muted;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q   <= {1'b1, {TICK_W{1'b0}}};
      prev_eq <= 1'b0;
      match_q <= 1'b0;
    end else begin
      if (wr_en) cmp_q <= wr_data;
      // a rewrite counts as "already equal" when it lands on the present count
      prev_eq <= wr_en ? low_hit(wr_data, tick) : eq_now;
      match_q <= fire;
    end
  end

  p_disable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_q[TICK_W] |=> !match_q);

  p_one_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    match_q |=> !match_q);

  p_on_equal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    match_q |-> ($past(cmp_q[TICK_W-1:0]) == $past(tick)));

  generate
    if (GATE_ON_HALT) begin : g_halt_chk
      p_halt_mute_r6: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> !match_q);
    end
  endgenerate
endmodule

// File: rtl/tcmp_hpend.sv
module tcmp_hpend #(
  parameter int CMP_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_i,
  input  logic             wr_en,
  input  logic [CMP_W-1:0] wr_data,
  output logic             pend_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (set_i)   pend_q <= 1'b1;
    else if (wr_en)   pend_q <= |wr_data;
  end

  p_pend_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> pend_q);

  p_pend_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !set_i) |=> (pend_q == $past(wr_data != '0)));
endmodule

// File: rtl/tcmp_top.sv
module tcmp_top #(
  parameter int TICK_W = tcmp_pkg::TICK_W_DEF,
  localparam int CMP_W = TICK_W + 1,
  localparam int NCH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TICK_W-1:0] tick_count,
  input  logic              strand_halted,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [CMP_W-1:0]  wr_data,
  input  logic [1:0]        rd_sel,
  output logic [CMP_W-1:0]  rd_data,
  output logic              soft_tick_set,
  output logic              hyp_match,
  output logic              hyp_irq
);
  import tcmp_pkg::*;

  logic [CMP_W-1:0] cmp_q   [NCH];
  logic             fire    [NCH];
  logic             match_q [NCH];
  logic             pend_q;
  logic             pend_wr;

  // channel 0 is supervisor, channel 1 is hypervisor (halt-gated)
  genvar gi;
  generate
    for (gi = 0; gi < NCH; gi++) begin : g_ch
      tcmp_channel #(
        .TICK_W      (TICK_W),
        .GATE_ON_HALT(gi == 1)
      ) u_ch (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick_count),
        .halted (strand_halted),
        .wr_en  (wr_en && (wr_sel == 2'(gi))),
        .wr_data(wr_data),
        .cmp_q  (cmp_q[gi]),
        .fire   (fire[gi]),
        .match_q(match_q[gi])
      );
    end
  endgenerate

  assign pend_wr = wr_en && (wr_sel == SEL_PEND);

  tcmp_hpend #(.CMP_W(CMP_W)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (fire[1]),
    .wr_en  (pend_wr),
    .wr_data(wr_data),
    .pend_q (pend_q)
  );

  always_comb begin
    case (tcmp_sel_e'(rd_sel))
      SEL_SUP:  rd_data = cmp_q[0];
      SEL_HYP:  rd_data = cmp_q[1];
      SEL_PEND: rd_data = {{(CMP_W-1){1'b0}}, pend_q};
      default:  rd_data = '0;
    endcase
  end

  assign soft_tick_set = match_q[0];
  assign hyp_match     = match_q[1];
  assign hyp_irq       = pend_q;
endmodule

// File: tb/tcmp_top_test.sv
module tcmp_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [62:0] tick_count = '0;
  logic        strand_halted = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [63:0] wr_data = '0;
  logic [1:0]  rd_sel = 2'd0;
  logic [63:0] rd_data;
  logic        soft_tick_set, hyp_match, hyp_irq;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;

  tcmp_top uut (
    .clk(clk), .rst_n(rst_n), .tick_count(tick_count),
    .strand_halted(strand_halted), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .soft_tick_set(soft_tick_set), .hyp_match(hyp_match), .hyp_irq(hyp_irq)
  );

  always #4 clk = ~clk;

  // {tick[31:0], halted, exp_soft, exp_hyp, exp_irq}; sup compare 10, hyp compare 20
  localparam logic [35:0] VEC [0:8] = '{
    {32'd9,  4'b0000},
    {32'd10, 4'b0100},
    {32'd11, 4'b0000},
    {32'd10, 4'b0100},
    {32'd10, 4'b0000},
    {32'd20, 4'b1000},
    {32'd21, 4'b0000},
    {32'd20, 4'b0011},
    {32'd20, 4'b0001}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic [62:0] t, input logic h);
    tick_count = t;
    strand_halted = h;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] s, input logic [63:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, input string req, input logic [63:0] exp);
    rd_sel = s;
    #1;
    chk(req, rd_data, exp);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        n_checks++; n_fails++;
        $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, "R1 sup word", 64'h8000_0000_0000_0000);
    rd(2'd1, "R1 hyp word", 64'h8000_0000_0000_0000);
    rd(2'd2, "R1 pending", 64'd0);
    chk("R1 outputs", {61'd0, soft_tick_set, hyp_match, hyp_irq}, 64'd0);

    // vector walk: R2 R4 R5 R6 R9
    wr(2'd0, 64'd10);
    wr(2'd1, 64'd20);
    for (int i = 0; i < 9; i++) begin
      step({31'd0, VEC[i][35:4]}, VEC[i][3]);
      chk($sformatf("R2/R4/R5/R6/R9 vec%0d", i),
          {61'd0, soft_tick_set, hyp_match, hyp_irq},
          {61'd0, VEC[i][2:0]});
    end

    // R7 pending write
    wr(2'd2, 64'd0);
    chk("R7 write zero", {63'd0, hyp_irq}, 64'd0);
    wr(2'd2, 64'h100);
    chk("R7 write nonzero", {63'd0, hyp_irq}, 64'd1);
    rd(2'd2, "R7 readback", 64'd1);
    wr(2'd2, 64'd0);
    chk("R7 clear", {63'd0, hyp_irq}, 64'd0);

    // R7 match beats same-cycle write of zero
    wr(2'd1, 64'd60);
    tick_count = 63'd60;
    wr(2'd2, 64'd0);
    chk("R7 set wins", {62'd0, hyp_match, hyp_irq}, 64'd3);

    // R3 disable flag
    wr(2'd0, {1'b1, 63'd30});
    rd(2'd0, "R3 readback", {1'b1, 63'd30});
    step(63'd29, 1'b0);
    step(63'd30, 1'b0);
    chk("R3 disabled silent", {63'd0, soft_tick_set}, 64'd0);

    // R2 all 63 bits compared
    wr(2'd0, {1'b0, 63'h4000_0000_0000_0005});
    step(63'd5, 1'b0);
    chk("R2 high bits differ", {63'd0, soft_tick_set}, 64'd0);
    step(63'h4000_0000_0000_0005, 1'b0);
    chk("R2 full match", {63'd0, soft_tick_set}, 64'd1);

    // R8 rearm at and behind count
    step(63'd50, 1'b0);
    wr(2'd0, 64'd50);
    chk("R8 at count write", {63'd0, soft_tick_set}, 64'd0);
    step(63'd50, 1'b0);
    chk("R8 at count hold", {63'd0, soft_tick_set}, 64'd0);
    wr(2'd0, 64'd45);
    step(63'd46, 1'b0);
    chk("R8 behind not yet", {63'd0, soft_tick_set}, 64'd0);
    step(63'd45, 1'b0);
    chk("R8 behind reached", {63'd0, soft_tick_set}, 64'd1);

    // R6 supervisor ignores halt
    step(63'd44, 1'b0);
    step(63'd45, 1'b1);
    chk("R6 sup while halted", {63'd0, soft_tick_set}, 64'd1);
    strand_halted = 1'b0;

    // R10 read and write map
    rd(2'd1, "R10 hyp word", 64'd60);
    rd(2'd3, "R10 unused select", 64'd0);
    wr(2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(2'd0, "R10 sel3 write sup", 64'd45);
    rd(2'd1, "R10 sel3 write hyp", 64'd60);
    rd(2'd2, "R10 sel3 write pend", 64'd1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule